// File: doc/BRIEF.md
# Paired-Page TLB Lookup Unit

This block is a fully associative translation buffer for 32-bit virtual addresses. Each slot describes two neighbouring virtual pages, an even one and an odd one, and holds a separate physical frame and permission flags for each of the two. A request carries a virtual address, the current 8-bit address-space identifier and an access kind (instruction fetch, load or store). The response is either a successful translation, with a physical address and a flag that says whether writes are allowed, or a fault code that names why the access cannot proceed.

Slots are loaded through a single indexed write port. A per-slot size field widens both pages of the pair by powers of two above the 4 KB base page. The compare across all slots is combinational. The response is registered and appears one clock after the request strobe. Choosing which slot to replace, and refilling it, is left to the logic around the block.

Top module: `tlb_lookup`

## Requirements
- R1: Synchronous active-high reset marks every slot as hardware-invalidated and clears `rsp_valid`. Until a slot is written, every lookup returns status 1 (no match).
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and the response fields hold the result for the request of that earlier cycle.
- R3: A slot takes part in a lookup only if it is not invalidated and either its global bit is set or its 8-bit identifier equals `req_asid`.
- R4: The slot's size field `wr_pmask[i]` stands for address bit 13+i. The effective mask is that field, placed at bits 28:13, ORed with ones in bits 12:0. Virtual bits outside the effective mask must equal the slot tag, which is held as address bits 31:13.
- R5: The even/odd selector is the highest bit of the effective mask: bit 12 for 4 KB pages, or bit 14 when the size field is 0x0003. When the selector is 0 the even descriptor is used; when it is 1 the odd descriptor is used.
- R6: On success, `rsp_paddr` is the selected 20-bit frame number shifted left by 12, ORed with the virtual address bits below the selector bit. `rsp_status` is 0 (hit).
- R7: A matched page is checked in this order. A clear valid flag gives status 2 (invalid). A fetch (access code 0) with execute-inhibit set gives status 3. A load (code 1, and code 3, which is checked as a load) with read-inhibit set gives status 4. A store (code 2) with the dirty flag clear gives status 5 (modified). The flag nibble is {execute-inhibit, read-inhibit, dirty, valid}, from bit 3 down to bit 0.
- R8: `rsp_writable` is 1 only on a hit whose selected dirty flag is set. On any fault, `rsp_paddr` and `rsp_writable` are zero.
- R9: When several slots match, the slot with the lowest index supplies the result.
- R10: A slot written in one cycle is used by lookups from the next cycle on. A lookup issued in the same cycle as the write still sees the old contents.
- R11: An address that no slot covers returns status 1 (no match).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_asid | input | 8 | Current address-space identifier |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 treated as load |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | 4 | Slot index to write |
| wr_vpn2 | input | 19 | Pair tag, virtual address bits 31:13 |
| wr_pmask | input | 16 | Page-size field for address bits 28:13 |
| wr_asid | input | 8 | Slot identifier |
| wr_global | input | 1 | Slot matches any identifier |
| wr_even_pfn | input | 20 | Frame number of the even page |
| wr_even_flags | input | 4 | Even page flags {xinh, rinh, dirty, valid} |
| wr_odd_pfn | input | 20 | Frame number of the odd page |
| wr_odd_flags | input | 4 | Odd page flags {xinh, rinh, dirty, valid} |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_status | output | 3 | 0 hit, 1 no match, 2 invalid, 3 exec-inhibit, 4 read-inhibit, 5 modified |
| rsp_paddr | output | 32 | Translated physical address, zero on a fault |
| rsp_writable | output | 1 | Write permitted for the translated page |

## Verification
A slot held with corrupt contents shows up on the first lookup that touches its pair, one cycle after the strobe. It appears as a wrong frame, a wrong status, or a no-match where a hit was due. A wrong selector bit or offset mask swaps the even and odd halves or corrupts the low physical bits, so the stimulus uses two page sizes and both halves. A broken priority chain between slots, or between the flag checks, shows up only when several conditions hold at once, so slots are loaded with overlapping tags and with pages that carry several flags together. A reset that fails to invalidate shows up as a stale hit right after reset.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;

    parameter int VA_W       = 32;
    parameter int PAGE_OFF_W = 12;
    parameter int MASK_W     = 16;
    parameter int ASID_W     = 8;
    parameter int ENTRIES    = 16;

    localparam int PAIR_OFF_W = PAGE_OFF_W + 1;
    localparam int VPN2_W     = VA_W - PAIR_OFF_W;
    localparam int PFN_W      = VA_W - PAGE_OFF_W;
    localparam int PA_W       = PFN_W + PAGE_OFF_W;
    localparam int IDX_W      = $clog2(ENTRIES);

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        ST_HIT      = 3'd0,
        ST_NOMATCH  = 3'd1,
        ST_INVALID  = 3'd2,
        ST_XINH     = 3'd3,
        ST_RINH     = 3'd4,
        ST_MODIFIED = 3'd5
    } status_e;

    typedef struct packed {
        logic xinh;
        logic rinh;
        logic dirty;
        logic valid;
    } page_flags_t;

    typedef struct packed {
        logic [PFN_W-1:0] pfn;
        page_flags_t      flags;
    } page_desc_t;

    typedef struct packed {
        logic              hinv;
        logic [VPN2_W-1:0] vpn2;
        logic [MASK_W-1:0] pmask;
        logic [ASID_W-1:0] asid;
        logic              global_en;
        page_desc_t        even;
        page_desc_t        odd;
    } tlb_entry_t;

    localparam tlb_entry_t EMPTY_ENTRY = '{hinv: 1'b1, default: '0};

    // Size field placed above the pair offset, with the pair offset bits forced to one.
    function automatic logic [VA_W-1:0] eff_mask(input logic [MASK_W-1:0] pmask);
        logic [VA_W-1:0] m;
        m = '0;
        m[PAIR_OFF_W +: MASK_W] = pmask;
        m[PAIR_OFF_W-1:0]       = '1;
        return m;
    endfunction

endpackage

// File: rtl/tlb_entry_match.sv
`timescale 1ns/1ps
module tlb_entry_match
    import tlb_pkg::*;
(
    input  tlb_entry_t        entry,
    input  logic [VA_W-1:0]   vaddr,
    input  logic [ASID_W-1:0] asid,
    output logic              hit,
    output logic              odd
);
    logic [VA_W-1:0] m;
    logic [VA_W-1:0] tag_full;
    logic            tag_eq;
    logic            id_ok;

    always_comb begin
        m        = eff_mask(entry.pmask);
        tag_full = {entry.vpn2, {PAIR_OFF_W{1'b0}}};
        tag_eq   = ((vaddr ^ tag_full) & ~m) == '0;
        id_ok    = entry.global_en || (entry.asid == asid);
        hit      = tag_eq && id_ok && !entry.hinv;
        odd      = |(vaddr & m & ~(m >> 1));
    end
endmodule

// File: rtl/tlb_priority.sv
`timescale 1ns/1ps
module tlb_priority
    import tlb_pkg::*;
#(
    parameter int N  = ENTRIES,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  hits,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) idx = IW'(i);
        end
        any   = |hits;
        grant = any ? (N'(1) << idx) : '0;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && ((grant & ~hits) == '0)); // R9
    AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (rst)
        any |-> ((hits & (grant - N'(1))) == '0)); // R9
endmodule

// File: rtl/tlb_perm_check.sv
`timescale 1ns/1ps
module tlb_perm_check
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  page_desc_t        desc,
    input  logic [MASK_W-1:0] pmask,
    input  logic [VA_W-1:0]   vaddr,
    input  acc_e              acc,
    output status_e           status,
    output logic [PA_W-1:0]   paddr,
    output logic              writable
);
    logic [VA_W-1:0] m;
    logic            is_fetch;
    logic            is_load;
    logic            is_store;

    always_comb begin
        m        = eff_mask(pmask);
        is_fetch = (acc == ACC_FETCH);
        is_store = (acc == ACC_STORE);
        is_load  = !is_fetch && !is_store;
        if (!desc.flags.valid)                     status = ST_INVALID;
        else if (is_fetch && desc.flags.xinh)      status = ST_XINH;
        else if (is_load && desc.flags.rinh)       status = ST_RINH;
        else if (is_store && !desc.flags.dirty)    status = ST_MODIFIED;
        else                                       status = ST_HIT;
        if (status == ST_HIT) begin
            paddr    = {desc.pfn, {PAGE_OFF_W{1'b0}}} | PA_W'(vaddr & (m >> 1));
            writable = desc.flags.dirty;
        end else begin
            paddr    = '0;
            writable = 1'b0;
        end
    end

    AST_STORE_HIT_WRITABLE: assert property (@(posedge clk) disable iff (rst)
        (status == ST_HIT && acc == ACC_STORE) |-> writable); // R7
    AST_INVALID_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        !desc.flags.valid |-> (status != ST_HIT && !writable)); // R7
endmodule

// File: rtl/tlb_lookup.sv
`timescale 1ns/1ps
module tlb_lookup
    import tlb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [VA_W-1:0]      req_vaddr,
    input  logic [ASID_W-1:0]    req_asid,
    input  logic [1:0]           req_acc,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [VPN2_W-1:0]    wr_vpn2,
    input  logic [MASK_W-1:0]    wr_pmask,
    input  logic [ASID_W-1:0]    wr_asid,
    input  logic                 wr_global,
    input  logic [PFN_W-1:0]     wr_even_pfn,
    input  logic [3:0]           wr_even_flags,
    input  logic [PFN_W-1:0]     wr_odd_pfn,
    input  logic [3:0]           wr_odd_flags,
    output logic                 rsp_valid,
    output logic [2:0]           rsp_status,
    output logic [PA_W-1:0]      rsp_paddr,
    output logic                 rsp_writable
);
    tlb_entry_t          tbl [ENTRIES];
    tlb_entry_t          wr_entry;
    logic [ENTRIES-1:0]  hit_vec;
    logic [ENTRIES-1:0]  odd_vec;
    logic [ENTRIES-1:0]  grant;
    logic [IDX_W-1:0]    win_idx;
    logic                any_hit;
    tlb_entry_t          win;
    page_desc_t          win_desc;
    status_e             chk_status;
    logic [PA_W-1:0]     chk_paddr;
    logic                chk_wr;
    status_e             nxt_status;
    logic [PA_W-1:0]     nxt_paddr;
    logic                nxt_wr;

    always_comb begin
        wr_entry.hinv      = 1'b0;
        wr_entry.vpn2      = wr_vpn2;
        wr_entry.pmask     = wr_pmask;
        wr_entry.asid      = wr_asid;
        wr_entry.global_en = wr_global;
        wr_entry.even      = '{pfn: wr_even_pfn, flags: page_flags_t'(wr_even_flags)};
        wr_entry.odd       = '{pfn: wr_odd_pfn,  flags: page_flags_t'(wr_odd_flags)};
    end

    // Slot storage: invalidated on reset, one indexed write per cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) tbl[i] <= EMPTY_ENTRY;
        end else if (wr_en) begin
            tbl[wr_idx] <= wr_entry;
        end
    end

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
            tlb_entry_match u_match (
                .entry (tbl[g]),
                .vaddr (req_vaddr),
                .asid  (req_asid),
                .hit   (hit_vec[g]),
                .odd   (odd_vec[g])
            );
        end
    endgenerate

    tlb_priority #(.N(ENTRIES), .IW(IDX_W)) u_prio (
        .clk   (clk),
        .rst   (rst),
        .hits  (hit_vec),
        .grant (grant),
        .idx   (win_idx),
        .any   (any_hit)
    );

    always_comb begin
        win      = tbl[win_idx];
        win_desc = odd_vec[win_idx] ? win.odd : win.even;
    end

    tlb_perm_check u_perm (
        .clk      (clk),
        .rst      (rst),
        .desc     (win_desc),
        .pmask    (win.pmask),
        .vaddr    (req_vaddr),
        .acc      (acc_e'(req_acc)),
        .status   (chk_status),
        .paddr    (chk_paddr),
        .writable (chk_wr)
    );

    always_comb begin
        if (any_hit) begin
            nxt_status = chk_status;
            nxt_paddr  = chk_paddr;
            nxt_wr     = chk_wr;
        end else begin
            nxt_status = ST_NOMATCH;
            nxt_paddr  = '0;
            nxt_wr     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_status   <= ST_NOMATCH;
            rsp_paddr    <= '0;
            rsp_writable <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_status   <= nxt_status;
                rsp_paddr    <= nxt_paddr;
                rsp_writable <= nxt_wr;
            end
        end
    end

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R2
    AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R2
    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status != ST_HIT) |-> (!rsp_writable && rsp_paddr == '0)); // R8
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !tbl[$past(wr_idx)].hinv); // R10
    AST_NOMATCH_WHEN_NONE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && hit_vec == '0) |=> (rsp_status == ST_NOMATCH)); // R11
endmodule

// File: tb/tlb_lookup_tb.sv
`timescale 1ns/1ps
module tlb_lookup_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [7:0]  req_asid = '0;
    logic [1:0]  req_acc = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [18:0] wr_vpn2 = '0;
    logic [15:0] wr_pmask = '0;
    logic [7:0]  wr_asid = '0;
    logic        wr_global = 1'b0;
    logic [19:0] wr_even_pfn = '0;
    logic [3:0]  wr_even_flags = '0;
    logic [19:0] wr_odd_pfn = '0;
    logic [3:0]  wr_odd_flags = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_status;
    logic [31:0] rsp_paddr;
    logic        rsp_writable;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tlb_lookup u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_asid(req_asid), .req_acc(req_acc),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn2(wr_vpn2), .wr_pmask(wr_pmask),
        .wr_asid(wr_asid), .wr_global(wr_global),
        .wr_even_pfn(wr_even_pfn), .wr_even_flags(wr_even_flags),
        .wr_odd_pfn(wr_odd_pfn), .wr_odd_flags(wr_odd_flags),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status),
        .rsp_paddr(rsp_paddr), .rsp_writable(rsp_writable)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [31:0] va;
        logic [7:0]  asid;
        logic [1:0]  acc;
        logic [2:0]  st;
        logic [31:0] pa;
        logic        wr;
    } vec_t;

    // Status: 0 hit, 1 no match, 2 invalid, 3 exec-inhibit, 4 read-inhibit, 5 modified
    localparam vec_t VECS [16] = '{
        '{4'd6,  32'h0040_0123, 8'h05, 2'd1, 3'd0, 32'h1234_5123, 1'b1}, // R6 even hit
        '{4'd7,  32'h0040_1ABC, 8'h05, 2'd2, 3'd5, 32'h0,         1'b0}, // R7 store, clean odd
        '{4'd8,  32'h0040_1ABC, 8'h05, 2'd1, 3'd0, 32'h00AB_CABC, 1'b0}, // R8 odd clean load
        '{4'd3,  32'h0040_0123, 8'h06, 2'd1, 3'd1, 32'h0,         1'b0}, // R3 wrong id
        '{4'd3,  32'h1000_1234, 8'h77, 2'd1, 3'd4, 32'h0,         1'b0}, // R3 global slot
        '{4'd4,  32'h1000_1234, 8'h77, 2'd0, 3'd0, 32'h2000_1234, 1'b0}, // R4 16 KB even
        '{4'd5,  32'h1000_5678, 8'h77, 2'd1, 3'd0, 32'h3000_5678, 1'b1}, // R5 bit 14 odd
        '{4'd7,  32'h1000_5678, 8'h77, 2'd0, 3'd3, 32'h0,         1'b0}, // R7 exec-inhibit
        '{4'd8,  32'h1000_5678, 8'h77, 2'd2, 3'd0, 32'h3000_5678, 1'b1}, // R8 dirty store
        '{4'd4,  32'h1000_8000, 8'h77, 2'd1, 3'd1, 32'h0,         1'b0}, // R4 outside pair
        '{4'd7,  32'h0040_2010, 8'h05, 2'd0, 3'd2, 32'h0,         1'b0}, // R7 invalid first
        '{4'd7,  32'h0040_3010, 8'h05, 2'd0, 3'd3, 32'h0,         1'b0}, // R7 xinh before rinh
        '{4'd7,  32'h0040_3010, 8'h05, 2'd1, 3'd4, 32'h0,         1'b0}, // R7 rinh
        '{4'd7,  32'h0040_3010, 8'h05, 2'd2, 3'd5, 32'h0,         1'b0}, // R7 modified
        '{4'd9,  32'h0060_0444, 8'h05, 2'd2, 3'd0, 32'h3333_3444, 1'b1}, // R9 lowest slot
        '{4'd7,  32'h0060_0444, 8'h05, 2'd3, 3'd0, 32'h3333_3444, 1'b1}  // R7 code 3 as load
    };

    task automatic check(input string tag, input logic [2:0] st, input logic [31:0] pa,
                         input logic wr);
        checks++;
        if (rsp_valid !== 1'b1 || rsp_status !== st || rsp_paddr !== pa || rsp_writable !== wr) begin
            errors++;
            $display("FAIL %s: got v=%0b st=%0d pa=%h wr=%0b, expected v=1 st=%0d pa=%h wr=%0b",
                     tag, rsp_valid, rsp_status, rsp_paddr, rsp_writable, st, pa, wr);
        end
    endtask

    task automatic write_slot(input logic [3:0] idx, input logic [31:0] base,
                              input logic [15:0] pm, input logic [7:0] id, input logic g,
                              input logic [19:0] ep, input logic [3:0] ef,
                              input logic [19:0] op, input logic [3:0] of_);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_vpn2 = base[31:13]; wr_pmask = pm;
        wr_asid = id; wr_global = g;
        wr_even_pfn = ep; wr_even_flags = ef; wr_odd_pfn = op; wr_odd_flags = of_;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Response is sampled on the negedge after the capturing posedge.
    task automatic lookup(input logic [31:0] va, input logic [7:0] id, input logic [1:0] acc);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_asid = id; req_acc = acc;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: got rsp_valid=%0b, expected 0 in reset", rsp_valid);
        end
        rst = 1'b0;

        lookup(32'h0040_0123, 8'h05, 2'd1);
        check("R1 empty after reset", 3'd1, 32'h0, 1'b0);

        write_slot(4'd0, 32'h0040_0000, 16'h0000, 8'h05, 1'b0, 20'h12345, 4'h3, 20'h00ABC, 4'h1);
        write_slot(4'd1, 32'h1000_0000, 16'h0003, 8'h09, 1'b1, 20'h20000, 4'h5, 20'h30004, 4'hB);
        write_slot(4'd2, 32'h0040_2000, 16'h0000, 8'h05, 1'b0, 20'h11111, 4'hC, 20'h22222, 4'hD);
        write_slot(4'd7, 32'h0060_0000, 16'h0000, 8'h05, 1'b0, 20'h77777, 4'h3, 20'h77777, 4'h3);
        write_slot(4'd3, 32'h0060_0000, 16'h0000, 8'h05, 1'b0, 20'h33333, 4'h3, 20'h33333, 4'h3);

        foreach (VECS[i]) begin
            lookup(VECS[i].va, VECS[i].asid, VECS[i].acc);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].st, VECS[i].pa, VECS[i].wr);
        end

        // R2: no strobe, no response
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R2: got rsp_valid=%0b, expected 0 without request", rsp_valid);
        end

        // R11: unmapped address
        lookup(32'hF000_0000, 8'h05, 2'd1);
        check("R11 unmapped", 3'd1, 32'h0, 1'b0);

        // R10: write and lookup in the same cycle see the old slot, next lookup sees the new
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd0; wr_vpn2 = 19'h00200; wr_pmask = 16'h0; wr_asid = 8'h05;
        wr_global = 1'b0; wr_even_pfn = 20'h55555; wr_even_flags = 4'h3;
        wr_odd_pfn = 20'h00ABC; wr_odd_flags = 4'h1;
        req_valid = 1'b1; req_vaddr = 32'h0040_0123; req_asid = 8'h05; req_acc = 2'd1;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        check("R10 same-cycle old contents", 3'd0, 32'h1234_5123, 1'b1);
        lookup(32'h0040_0123, 8'h05, 2'd1);
        check("R10 new contents", 3'd0, 32'h5555_5123, 1'b1);

        // R1: reset again wipes all slots
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        lookup(32'h0060_0444, 8'h05, 2'd1);
        check("R1 wiped by reset", 3'd1, 32'h0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule